// File: doc/BRIEF.md
# Stepped Fine DAC Code Register

This block keeps the 12-bit code that drives the fine stage of a two-stage DAC, together with the two 8-bit reference codes of the coarse stage. Software loads the fine code, the step size and the coarse pair through a plain register-write port. Between writes, an external strobe nudges the fine code. Each rising edge of the strobe moves the code by the programmed step size. The direction input sets whether the code moves up or down.

The strobe may come from any clock domain. It passes through a synchronizer and an edge detector, and every register runs on the system clock. The fine code saturates at both ends of its range and never wraps. The write port has no back-pressure: every cycle with `wr_en` high is taken. Outputs change only on clock edges.

Top module: `fine_step_dac`

## Requirements
- R1: After reset, the fine code, the step size, the high coarse code and the low coarse code are all 0.
- R2: A write with `wr_sel` = 0 loads `wr_data[11:0]` into the fine code. Bits 15:12 are ignored, and the new code shows on `fine_code` after the next clock edge.
- R3: A write with `wr_sel` = 1 loads `wr_data[11:0]` into the unsigned step size. The step size is seen only through the amount later steps move the code.
- R4: A write with `wr_sel` = 2 loads `wr_data[15:8]` into `coarse_hi` and `wr_data[7:0]` into `coarse_lo`.
- R5: A write with `wr_sel` = 3 changes no register.
- R6: A rising edge of `step_strobe` changes the fine code on the third rising clock edge after it: two synchronizer stages, then the edge detector. A strobe held high gives exactly one step.
- R7: `step_dir` high adds the step size and low subtracts it. The level is sampled at the edge that applies the step.
- R8: An up step that would pass 4095 gives 4095. A down step that would go below 0 gives 0.
- R9: If a fine-code write and a step fall on the same clock edge, the written value is kept and that step is lost.
- R10: With no fine-code write and no step, the fine code holds its value. The coarse codes change only on a coarse write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per high cycle |
| wr_sel | input | 2 | Target: 0 fine, 1 step size, 2 coarse pair, 3 none |
| wr_data | input | 16 | Write data |
| step_dir | input | 1 | 1 = step up, 0 = step down |
| step_strobe | input | 1 | Asynchronous step request, acts on its rising edge |
| fine_code | output | 12 | Current fine DAC code |
| coarse_hi | output | 8 | High coarse reference code |
| coarse_lo | output | 8 | Low coarse reference code |

## Verification
A register write is due on the outputs one clock edge after the cycle that presents it. A strobe rise is due on the third edge after it. The bench drives inputs just after a falling clock edge and reads outputs at the falling edge that follows the edge where a result becomes due. It also reads `fine_code` before that edge, to show that a step does not arrive early. For a write and a step on the same edge, the write is placed in the cycle before the third edge, so that both land on the same edge.

// File: rtl/fine_dac_pkg.sv
package fine_dac_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_FINE   = 2'd0,
    SEL_STEP   = 2'd1,
    SEL_COARSE = 2'd2,
    SEL_NONE   = 2'd3
  } wr_target_e;
endpackage

// File: rtl/strobe_edge_sync.sv
module strobe_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sat_step_alu.sv
module sat_step_alu #(
  parameter int unsigned CODE_W = 12
) (
  input  logic [CODE_W-1:0] code_in,
  input  logic [CODE_W-1:0] step_in,
  input  logic              go_up,
  output logic [CODE_W-1:0] code_out
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [CODE_W:0] sum_ext;

  always_comb begin
    sum_ext = {1'b0, code_in} + {1'b0, step_in};
    if (go_up) begin
      code_out = sum_ext[CODE_W] ? CODE_MAX : sum_ext[CODE_W-1:0];
    end else begin
      code_out = (step_in > code_in) ? '0 : (code_in - step_in);
    end
  end
endmodule

// File: rtl/fine_step_dac.sv
module fine_step_dac #(
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned COARSE_W    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [2*COARSE_W-1:0]   wr_data,
  input  logic                    step_dir,
  input  logic                    step_strobe,
  output logic [CODE_W-1:0]       fine_code,
  output logic [COARSE_W-1:0]     coarse_hi,
  output logic [COARSE_W-1:0]     coarse_lo
);
  import fine_dac_pkg::*;

  localparam int unsigned REG_W = 2 * COARSE_W;

  logic [CODE_W-1:0] fine_q;
  logic [CODE_W-1:0] step_q;
  logic [CODE_W-1:0] stepped_code;
  logic              step_pulse;
  logic              wr_fine;
  logic              wr_step;
  logic              wr_coarse;

  assign wr_fine   = wr_en && (wr_target_e'(wr_sel) == SEL_FINE);
  assign wr_step   = wr_en && (wr_target_e'(wr_sel) == SEL_STEP);
  assign wr_coarse = wr_en && (wr_target_e'(wr_sel) == SEL_COARSE);

  strobe_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  (step_strobe),
    .rise_pulse(step_pulse)
  );

  sat_step_alu #(.CODE_W(CODE_W)) u_alu (
    .code_in (fine_q),
    .step_in (step_q),
    .go_up   (step_dir),
    .code_out(stepped_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fine_q <= '0;
    end else if (wr_fine) begin
      fine_q <= wr_data[CODE_W-1:0];
    end else if (step_pulse) begin
      fine_q <= stepped_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (wr_step) begin
      step_q <= wr_data[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_hi <= '0;
      coarse_lo <= '0;
    end else if (wr_coarse) begin
      coarse_hi <= wr_data[REG_W-1:COARSE_W];
      coarse_lo <= wr_data[COARSE_W-1:0];
    end
  end

  assign fine_code = fine_q;
endmodule

// File: rtl/fine_step_dac_chk.sv
module fine_step_dac_chk #(
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned COARSE_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [1:0]            wr_sel,
  input logic [2*COARSE_W-1:0] wr_data,
  input logic                  step_dir,
  input logic                  step_pulse,
  input logic [CODE_W-1:0]     fine_code,
  input logic [COARSE_W-1:0]   coarse_hi,
  input logic [COARSE_W-1:0]   coarse_lo
);
  logic wr_f;
  logic wr_c;
  assign wr_f = wr_en && (wr_sel == 2'd0);
  assign wr_c = wr_en && (wr_sel == 2'd2);

  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (fine_code == '0 && coarse_hi == '0 && coarse_lo == '0);
    end
  end

  a_r2_fine_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_f |=> fine_code == $past(wr_data[CODE_W-1:0]));

  a_r4_coarse_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c |=> {coarse_hi, coarse_lo} == $past(wr_data));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse);

  a_r7_up_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && step_dir && !wr_f) |=> fine_code >= $past(fine_code));

  a_r7_down_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && !step_dir && !wr_f) |=> fine_code <= $past(fine_code));

  a_r10_fine_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_f && !step_pulse) |=> $stable(fine_code));

  a_r10_coarse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_c |=> ($stable(coarse_hi) && $stable(coarse_lo)));
endmodule

bind fine_step_dac fine_step_dac_chk #(
  .CODE_W  (CODE_W),
  .COARSE_W(COARSE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .step_dir  (step_dir),
  .step_pulse(step_pulse),
  .fine_code (fine_code),
  .coarse_hi (coarse_hi),
  .coarse_lo (coarse_lo)
);

// File: tb/fine_step_dac_tb_top.sv
module fine_step_dac_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        step_dir = 1'b0;
  logic        step_strobe = 1'b0;
  logic [11:0] fine_code;
  logic [7:0]  coarse_hi;
  logic [7:0]  coarse_lo;

  int checks = 0;
  int errors = 0;
  logic [11:0] m_fine = '0;
  logic [11:0] m_step = '0;
  logic [7:0]  m_hi = '0;
  logic [7:0]  m_lo = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fine_step_dac dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .step_dir(step_dir), .step_strobe(step_strobe),
    .fine_code(fine_code), .coarse_hi(coarse_hi), .coarse_lo(coarse_lo)
  );

  function automatic logic [11:0] model_step(logic [11:0] c, logic [11:0] s, logic up);
    int v;
    v = up ? int'(c) + int'(s) : int'(c) - int'(s);
    if (v > 4095) v = 4095;
    if (v < 0) v = 0;
    return v[11:0];
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, fine_code, m_fine);
    chk(req, coarse_hi, m_hi);
    chk(req, coarse_lo, m_lo);
  endtask

  task automatic do_write(logic [1:0] sel, logic [15:0] d, string req);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: m_fine = d[11:0];
      2'd1: m_step = d[11:0];
      2'd2: begin m_hi = d[15:8]; m_lo = d[7:0]; end
      default: ;
    endcase
    chk_all(req);
  endtask

  task automatic do_step(logic dir, string req);
    step_dir = dir;
    step_strobe = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R6 not early", fine_code, m_fine);
    @(posedge clk); @(negedge clk);
    m_fine = model_step(m_fine, m_step, dir);
    chk(req, fine_code, m_fine);
    step_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_step(logic [11:0] s);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = {4'hF, s};
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    m_step = s;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7121));
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after release");
    // R3: step size is 0 after reset, so a step leaves the code unchanged
    do_step(1'b1, "R1 R3 zero step");

    do_write(2'd0, 16'hA123, "R2 fine write, top bits ignored");
    do_write(2'd2, 16'h5AC3, "R4 coarse write");
    do_write(2'd3, 16'hFFFF, "R5 ignored select");
    set_step(12'd16);
    do_step(1'b1, "R3 R7 up by step");
    do_step(1'b0, "R7 down by step");

    // R6: a strobe held high gives one step only
    step_dir = 1'b1; step_strobe = 1'b1;
    repeat (3) @(negedge clk);
    m_fine = model_step(m_fine, m_step, 1'b1);
    repeat (6) @(negedge clk);
    chk("R6 held strobe one step", fine_code, m_fine);
    step_strobe = 1'b0;
    repeat (3) @(negedge clk);

    // R8 saturation at both ends
    do_write(2'd0, 16'd4090, "R2 near max");
    set_step(12'd100);
    do_step(1'b1, "R8 saturate high");
    do_write(2'd0, 16'd30, "R2 near zero");
    do_step(1'b0, "R8 saturate low");
    set_step(12'd4095);
    do_step(1'b1, "R8 full step up");

    // R9: write and step land on the same edge
    set_step(12'd5);
    do_write(2'd0, 16'd1000, "R2 before clash");
    step_dir = 1'b1; step_strobe = 1'b1;
    @(negedge clk); @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'd777;
    @(negedge clk);
    wr_en = 1'b0;
    m_fine = 12'd777;
    chk("R9 write wins", fine_code, m_fine);
    repeat (4) @(negedge clk);
    chk("R9 step dropped", fine_code, m_fine);
    step_strobe = 1'b0;
    repeat (3) @(negedge clk);

    // R10 hold with idle inputs
    repeat (5) @(negedge clk);
    chk_all("R10 idle hold");

    for (int i = 0; i < 60; i++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: do_write(2'd0, 16'($urandom), "R2 random fine");
        1: begin set_step(12'($urandom)); chk_all("R3 R10 step write"); end
        2: do_write(2'd2, 16'($urandom), "R4 random coarse");
        3: do_write(2'd3, 16'($urandom), "R5 random ignored");
        default: do_step(1'($urandom), "R7 R8 random step");
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule